// File: doc/BRIEF.md
# Auto-Reload Countdown Timer Channel Array

This block holds five countdown channels behind one small register bus. Software fills a per-channel count buffer, then drives each channel through a single shared control word: a rising manual-update bit copies the buffer into that channel's counter, and a rising start bit lets the counter step down by one on every cycle its tick strobe is high. When a channel runs out it raises a one-cycle expiry pulse. It then either reloads from its buffer and keeps running, or clears its own start bit and stays at zero.

Channels 0 to 3 also carry a compare buffer and drive a level output. The output is high while the counter is above the compare value, and an invert bit in the control word flips it. The last channel has no compare buffer and no invert bit, so its auto-reload bit sits one place lower in the control word. The expiry pulses are meant for a separate interrupt block. The two configuration words are plain storage for the clock-setup logic that produces the tick strobes.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset the control word, both configuration words, all count and compare buffers and all counters read zero, no channel runs, and `expire_o` and `wave_o` are zero.
- R2: Byte offsets: configuration words at 0x00 and 0x04, control word at 0x08. For channel n from 0 to 3 the count buffer is at 0x0C+0xC·n, the compare buffer at 0x10+0xC·n and the live counter at 0x14+0xC·n. Channel 4 has its count buffer at 0x3C and its live counter at 0x40. Writes to counter offsets and to any other offset change nothing, and other offsets read zero. Read data is combinational while `bus_req_i` is high and `bus_we_i` is low, and zero otherwise.
- R3: Control bit layout: channel 0 uses bits 0,1,2,3 as start, manual update, invert and auto-reload. Channel n from 1 to 3 uses the same order starting at bit 4+4·n. Channel 4 uses bit 20 as start, bit 21 as manual update and bit 22 as auto-reload.
- R4: A control write that moves a channel's manual-update bit from 0 to 1 loads that channel's count buffer into its counter at that clock edge. A write that leaves the bit at 1 does not reload.
- R5: A control write that moves a start bit from 0 to 1 starts the channel. A write that moves it from 1 to 0 stops it, and the counter keeps its value.
- R6: A running channel decrements its counter by one on each clock edge where its tick bit is high. Ticks to a stopped channel have no effect.
- R7: A tick to a running channel whose counter is 1 or 0 is an expiry. It sets that channel's `expire_o` bit for exactly the following cycle.
- R8: On expiry with the auto-reload bit set, the counter reloads from the count buffer, the start bit stays set and counting continues.
- R9: On expiry with the auto-reload bit clear, the counter becomes zero and the block clears that channel's start bit in the control word. No other control bit changes unless the bus writes the control word.
- R10: For channels 0 to 3, `wave_o[n]` equals (counter > compare buffer) XOR invert bit.
- R11: In a cycle that writes the control word, ticks are dropped for all channels.
- R12: Both configuration words store any written value and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data |
| tick_i | input | 5 | Per-channel count strobe |
| expire_o | output | 5 | Per-channel one-cycle expiry pulse |
| wave_o | output | 4 | Compare outputs of channels 0 to 3 |

## Verification
A wrong counter shows up on `wave_o` at once whenever the compare value lies between the right and the wrong count. It also moves the expiry pulse by as many ticks as the error, and any read of the live-counter offset exposes it in the same cycle. A lost or misplaced control bit shows as an expiry at the wrong time, a channel that keeps running or reloading when it should halt, or a control word read-back with the start bit still set after a one-shot ends. The bench mirrors every register and counter and compares `expire_o` and `wave_o` after every edge, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int NCH  = 5;
  localparam int NCMP = 4;
  localparam int AW   = 7;

  localparam logic [AW-1:0] OFS_CFG0 = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CFG1 = AW'(8'h04);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);

  function automatic int start_pos(int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int upd_pos(int ch);
    return start_pos(ch) + 1;
  endfunction

  function automatic int inv_pos(int ch);
    return start_pos(ch) + 2;
  endfunction

  // last channel has no invert bit, so auto-reload moves down one place
  function automatic int auto_pos(int ch);
    return (ch == NCH - 1) ? start_pos(ch) + 2 : start_pos(ch) + 3;
  endfunction

  function automatic logic [AW-1:0] buf_ofs(int ch);
    return AW'(12 + 12 * ch);
  endfunction

  function automatic logic [AW-1:0] cmp_ofs(int ch);
    return AW'(16 + 12 * ch);
  endfunction

  function automatic logic [AW-1:0] obs_ofs(int ch);
    return (ch == NCH - 1) ? AW'(64) : AW'(20 + 12 * ch);
  endfunction

  function automatic logic [31:0] start_mask();
    logic [31:0] m;
    m = '0;
    for (int ch = 0; ch < NCH; ch++) m[start_pos(ch)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rtb_chan.sv
module rtb_chan #(
  parameter int DATA_W  = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic              start_i,
  input  logic              upd_i,
  input  logic              upd_new_i,
  input  logic              auto_i,
  input  logic              inv_i,
  input  logic [DATA_W-1:0] buf_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o,
  output logic              stop_o,
  output logic              wave_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              exp_q;
  logic              ld, step, fire;

  assign ld   = ctrl_wr_i & upd_new_i & ~upd_i;
  // control writes take the cycle; ticks are dropped
  assign step = ~ctrl_wr_i & start_i & tick_i;
  assign fire = step & (cnt_q <= DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= fire;
      if (ld)        cnt_q <= buf_i;
      else if (fire) cnt_q <= auto_i ? buf_i : '0;
      else if (step) cnt_q <= cnt_q - DATA_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
  assign stop_o   = fire & ~auto_i;

  if (HAS_CMP) begin : g_cmp
    assign wave_o = (cnt_q > cmp_i) ^ inv_i;
  end else begin : g_nocmp
    logic unused_cmp;
    assign unused_cmp = ^{cmp_i, inv_i};
    assign wave_o = 1'b0;
  end

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && upd_new_i && !upd_i) |=> (cnt_q == $past(buf_i)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr_i && !start_i) |=> $stable(cnt_q));
  // R7
  expire_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_i && start_i && !ctrl_wr_i));
  // R8
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && $past(auto_i)) |-> (cnt_q == $past(buf_i)));
  // R9
  oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !$past(auto_i)) |-> (!start_i && cnt_q == '0));
endmodule

// File: rtl/rtb_regs.sv
module rtb_regs
  import rtb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_req_i,
  input  logic                        bus_we_i,
  input  logic [AW-1:0]               bus_addr_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  input  logic [NCH-1:0][DATA_W-1:0]  cnt_i,
  input  logic [NCH-1:0]              stop_i,
  output logic [DATA_W-1:0]           ctrl_o,
  output logic                        ctrl_wr_o,
  output logic [NCH-1:0][DATA_W-1:0]  buf_o,
  output logic [NCMP-1:0][DATA_W-1:0] cmp_o
);
  localparam logic [DATA_W-1:0] START_MASK = DATA_W'(start_mask());

  logic [1:0][DATA_W-1:0]      cfg_q;
  logic [DATA_W-1:0]           ctrl_q;
  logic [NCH-1:0][DATA_W-1:0]  buf_q;
  logic [NCMP-1:0][DATA_W-1:0] cmp_q;
  logic                        wr, ctrl_wr;

  assign wr      = bus_req_i & bus_we_i;
  assign ctrl_wr = wr & (bus_addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      buf_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr) begin
        if (bus_addr_i == OFS_CFG0) cfg_q[0] <= bus_wdata_i;
        if (bus_addr_i == OFS_CFG1) cfg_q[1] <= bus_wdata_i;
        for (int ch = 0; ch < NCH; ch++)
          if (bus_addr_i == buf_ofs(ch)) buf_q[ch] <= bus_wdata_i;
        for (int ch = 0; ch < NCMP; ch++)
          if (bus_addr_i == cmp_ofs(ch)) cmp_q[ch] <= bus_wdata_i;
      end
      if (ctrl_wr) ctrl_q <= bus_wdata_i;
      else begin
        for (int ch = 0; ch < NCH; ch++)
          if (stop_i[ch]) ctrl_q[start_pos(ch)] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (bus_addr_i == OFS_CFG0) bus_rdata_o = cfg_q[0];
      if (bus_addr_i == OFS_CFG1) bus_rdata_o = cfg_q[1];
      if (bus_addr_i == OFS_CTRL) bus_rdata_o = ctrl_q;
      for (int ch = 0; ch < NCH; ch++) begin
        if (bus_addr_i == buf_ofs(ch)) bus_rdata_o = buf_q[ch];
        if (bus_addr_i == obs_ofs(ch)) bus_rdata_o = cnt_i[ch];
      end
      for (int ch = 0; ch < NCMP; ch++)
        if (bus_addr_i == cmp_ofs(ch)) bus_rdata_o = cmp_q[ch];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign ctrl_wr_o = ctrl_wr;
  assign buf_o     = buf_q;
  assign cmp_o     = cmp_q;

  // R9
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_wr) |-> ((ctrl_q & ~START_MASK) == ($past(ctrl_q) & ~START_MASK)));
  // R9
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop_i) != '0 && !$past(ctrl_wr)) |-> ((ctrl_q & START_MASK) != ($past(ctrl_q) & START_MASK)));
endmodule

// File: rtl/reload_timer_bank.sv
module reload_timer_bank
  import rtb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [6:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [4:0]        tick_i,
  output logic [4:0]        expire_o,
  output logic [3:0]        wave_o
);
  logic [DATA_W-1:0]           ctrl_q;
  logic                        ctrl_wr;
  logic [NCH-1:0][DATA_W-1:0]  buf_q;
  logic [NCMP-1:0][DATA_W-1:0] cmp_q;
  logic [NCH-1:0][DATA_W-1:0]  cnt;
  logic [NCH-1:0]              stop;
  logic                        unused_ctrl;

  assign unused_ctrl = ^ctrl_q;

  rtb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_i       (cnt),
    .stop_i      (stop),
    .ctrl_o      (ctrl_q),
    .ctrl_wr_o   (ctrl_wr),
    .buf_o       (buf_q),
    .cmp_o       (cmp_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit HAS_CMP = (ch < NCMP);
    logic              inv, wave;
    logic [DATA_W-1:0] cmp;

    if (HAS_CMP) begin : g_cmp
      assign inv        = ctrl_q[inv_pos(ch)];
      assign cmp        = cmp_q[ch];
      assign wave_o[ch] = wave;
    end else begin : g_nocmp
      logic unused_wave;
      assign inv         = 1'b0;
      assign cmp         = '0;
      assign unused_wave = wave;
    end

    rtb_chan #(.DATA_W(DATA_W), .HAS_CMP(HAS_CMP)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i[ch]),
      .ctrl_wr_i (ctrl_wr),
      .start_i   (ctrl_q[start_pos(ch)]),
      .upd_i     (ctrl_q[upd_pos(ch)]),
      .upd_new_i (bus_wdata_i[upd_pos(ch)]),
      .auto_i    (ctrl_q[auto_pos(ch)]),
      .inv_i     (inv),
      .buf_i     (buf_q[ch]),
      .cmp_i     (cmp),
      .cnt_o     (cnt[ch]),
      .expire_o  (expire_o[ch]),
      .stop_o    (stop[ch]),
      .wave_o    (wave)
    );
  end
endmodule

// File: tb/reload_timer_bank_tb_top.sv
module reload_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tick = '0;
  logic [4:0]  expire;
  logic [3:0]  wave;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cfg [2];
  logic [31:0] m_ctrl;
  logic [31:0] m_buf [5];
  logic [31:0] m_cmp [4];
  logic [31:0] m_cnt [5];
  logic [4:0]  m_exp;

  always #2 clk = ~clk;

  reload_timer_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .expire_o(expire), .wave_o(wave)
  );

  function automatic int sp(int ch); return (ch == 0) ? 0 : 4 + 4 * ch; endfunction
  function automatic int ap(int ch); return (ch == 4) ? 22 : sp(ch) + 3; endfunction

  function automatic logic [31:0] exp_read(logic [6:0] a);
    if (a == 7'h00) return m_cfg[0];
    if (a == 7'h04) return m_cfg[1];
    if (a == 7'h08) return m_ctrl;
    if (a == 7'h3C) return m_buf[4];
    if (a == 7'h40) return m_cnt[4];
    for (int n = 0; n < 4; n++) begin
      if (a == 7'(12 + 12 * n)) return m_buf[n];
      if (a == 7'(16 + 12 * n)) return m_cmp[n];
      if (a == 7'(20 + 12 * n)) return m_cnt[n];
    end
    return 32'h0;
  endfunction

  function automatic logic [3:0] exp_wave();
    logic [3:0] w;
    for (int n = 0; n < 4; n++) w[n] = (m_cnt[n] > m_cmp[n]) ^ m_ctrl[sp(n) + 2];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic r, input logic w, input logic [6:0] a,
                            input logic [31:0] d, input logic [4:0] tk);
    logic cw;
    logic [4:0] ne;
    cw = r && w && (a == 7'h08);
    ne = '0;
    for (int ch = 0; ch < 5; ch++) begin
      if (cw) begin
        if (d[sp(ch) + 1] && !m_ctrl[sp(ch) + 1]) m_cnt[ch] = m_buf[ch];
      end else if (m_ctrl[sp(ch)] && tk[ch]) begin
        if (m_cnt[ch] <= 1) begin
          ne[ch] = 1'b1;
          if (m_ctrl[ap(ch)]) m_cnt[ch] = m_buf[ch];
          else begin
            m_cnt[ch] = 0;
            m_ctrl[sp(ch)] = 1'b0;
          end
        end else m_cnt[ch] = m_cnt[ch] - 1;
      end
    end
    if (cw) m_ctrl = d;
    if (r && w) begin
      if (a == 7'h00) m_cfg[0] = d;
      if (a == 7'h04) m_cfg[1] = d;
      if (a == 7'h3C) m_buf[4] = d;
      for (int n = 0; n < 4; n++) begin
        if (a == 7'(12 + 12 * n)) m_buf[n] = d;
        if (a == 7'(16 + 12 * n)) m_cmp[n] = d;
      end
    end
    m_exp = ne;
  endtask

  task automatic cyc(input logic r, input logic w, input logic [6:0] a,
                     input logic [31:0] d, input logic [4:0] tk, input string tag);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; tick = tk;
    #1;
    if (r && !w) chk(tag, rdata, exp_read(a));
    @(posedge clk);
    model_edge(r, w, a, d, tk);
    #1;
    chk("R7 expire", {27'b0, expire}, {27'b0, m_exp});
    chk("R10 wave", {28'b0, wave}, {28'b0, exp_wave()});
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [4:0] tk = 5'b0);
    cyc(1'b1, 1'b1, a, d, tk, "write");
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 5'b0, tag);
  endtask

  task automatic idle(input logic [4:0] tk);
    cyc(1'b0, 1'b0, 7'h0, 32'h0, tk, "idle");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20251));
    m_cfg = '{default: '0}; m_ctrl = '0; m_buf = '{default: '0};
    m_cmp = '{default: '0}; m_cnt = '{default: '0}; m_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    // R1
    chk("R1 expire", {27'b0, expire}, 32'h0);
    chk("R1 wave", {28'b0, wave}, 32'h0);
    rd(7'h08, "R1 ctrl");
    rd(7'h0C, "R1 buf0");
    rd(7'h14, "R1 cnt0");
    rd(7'h40, "R1 cnt4");
    rd(7'h00, "R1 cfg0");
    // R12
    wr(7'h00, 32'hA5A5_0101);
    wr(7'h04, 32'h0000_1234);
    rd(7'h00, "R12 cfg0");
    rd(7'h04, "R12 cfg1");
    // R2
    wr(7'h24, 32'd5);
    wr(7'h28, 32'd2);
    rd(7'h24, "R2 buf2");
    rd(7'h28, "R2 cmp2");
    wr(7'h20, 32'd77);
    rd(7'h20, "R2 cnt1 write ignored");
    wr(7'h44, 32'd9);
    rd(7'h44, "R2 unmapped 0x44");
    rd(7'h48, "R2 unmapped 0x48");
    // R4
    wr(7'h0C, 32'd6);
    wr(7'h08, 32'h2);
    rd(7'h14, "R4 load");
    wr(7'h0C, 32'd3);
    wr(7'h08, 32'h2);
    rd(7'h14, "R4 no reload while held");
    // R5 / R6
    wr(7'h08, 32'h3);
    idle(5'b00001);
    idle(5'b00001);
    rd(7'h14, "R6 decrement");
    idle(5'b00000);
    rd(7'h14, "R6 no tick");
    wr(7'h08, 32'h2);
    idle(5'b00001);
    idle(5'b00001);
    rd(7'h14, "R5 stop holds");
    // R7 / R9 one-shot
    wr(7'h08, 32'h3);
    repeat (4) idle(5'b00001);
    rd(7'h08, "R9 start cleared");
    rd(7'h14, "R9 counter zero");
    idle(5'b00001);
    rd(7'h14, "R9 stays stopped");
    // R8 auto-reload on channel 1
    wr(7'h18, 32'd2);
    wr(7'h08, 32'h200);
    wr(7'h08, 32'hB00);
    idle(5'b00010);
    idle(5'b00010);
    rd(7'h20, "R8 reloaded");
    rd(7'h08, "R8 start kept");
    idle(5'b00010);
    rd(7'h20, "R8 still counting");
    // R3 channel 4 layout
    wr(7'h3C, 32'd1);
    wr(7'h08, 32'h0020_0000);
    wr(7'h08, 32'h0070_0000);
    idle(5'b10000);
    rd(7'h08, "R3 ch4 auto at bit 22");
    rd(7'h40, "R3 ch4 reloaded");
    // R10 channel 2 with invert
    wr(7'h08, 32'h0000_2000);
    rd(7'h2C, "R10 ch2 load");
    wr(7'h08, 32'h0000_7000);
    idle(5'b00100);
    wr(7'h08, 32'h0000_3000);
    // R11 control write with ticks
    wr(7'h08, 32'h0000_3000, 5'b11111);
    rd(7'h2C, "R11 tick dropped");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [6:0] a;
      logic [4:0] tk;
      op = int'($urandom % 16);
      tk = 5'($urandom);
      a = 7'(($urandom % 20) * 4);
      if (op < 2) wr(7'h08, $urandom & 32'h007F_FF0F, tk);
      else if (op < 5) wr(a, $urandom % 8, tk);
      else if (op < 8) cyc(1'b1, 1'b0, a, 32'h0, tk, "R2 random read");
      else idle(tk);
    end
    finish_run();
  end
endmodule